// File: doc/BRIEF.md
# Dual-Channel DAC Data Register Unit

This block is the register-side front end of a two-channel 12-bit digital-to-analog converter. Software writes sample values through a 32-bit write port into data registers of three packing formats: 12-bit right-aligned, 12-bit left-aligned and 8-bit right-aligned. Each format exists once per channel and once as a combined register that carries both channels in a single word. The block realigns each written field into a 12-bit holding register per channel. The holding registers have no bus address of their own; they change only through the formatted data registers.

A holding value reaches the channel's 12-bit output bus through a per-channel output register. Each channel moves its holding value to the output on its own selectable condition. With its trigger disabled, the channel copies on every clock, so the output follows a write one clock later. With its trigger enabled, the channel copies only after a trigger event. The event comes from a self-clearing software trigger request or from the rising edge of an asynchronous external trigger, which is brought into the clock domain first. A combined write lets one bus access update both channels in the same cycle. Any result that a combined write gives can also be reached by writing the two channels one after the other.

Top module: `dacDataRegs`

## Requirements
- R1: After reset both output buses `dout1` and `dout2` are zero.
- R2: A write to word address 0 (channel 1) or 3 (channel 2) takes `wrData[11:0]` as that channel's 12-bit value.
- R3: A write to word address 1 (channel 1) or 4 (channel 2) takes `wrData[15:4]` as that channel's 12-bit value.
- R4: A write to word address 2 (channel 1) or 5 (channel 2) places `wrData[7:0]` in bits [11:4] of that channel's value and sets bits [3:0] to zero.
- R5: A write to word address 6 sets channel 1 from `wrData[11:0]` and channel 2 from `wrData[27:16]` with the same single write.
- R6: A write to word address 7 sets channel 1 from `wrData[15:4]` and channel 2 from `wrData[31:20]` with the same single write.
- R7: A write to word address 8 sets channel 1 bits [11:4] from `wrData[7:0]` and channel 2 bits [11:4] from `wrData[15:8]`, with bits [3:0] of both zero.
- R8: When `trigEn[c]` is 0, a write sampled at one rising edge shows on that channel's output after the next rising edge.
- R9: When `trigEn[c]` is 1, a write leaves that channel's output unchanged until a trigger event of the selected source.
- R10: With `trigEn[c]`=1 and `trigSrcExt[c]`=0, `swTrig[c]` sampled high at one rising edge copies the holding value to the output at the next edge. The request then clears itself, so a later write stays unchanged at the output.
- R11: With `trigEn[c]`=1 and `trigSrcExt[c]`=1, `extTrig[c]` passes through a two-flop synchronizer. A rise before edge 0 copies at edge 2 and not earlier. A held high level and a falling edge copy nothing.
- R12: A channel ignores `swTrig[c]` while its source is external and ignores `extTrig[c]` while its source is software.
- R13: Writes to word addresses 9 to 15 change neither output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | 4 | Word address of the data register |
| wrData | input | 32 | Write data |
| trigEn | input | 2 | Per-channel trigger enable (bit 0 = channel 1) |
| trigSrcExt | input | 2 | Per-channel trigger source, 1 = external, 0 = software |
| swTrig | input | 2 | Per-channel software trigger request |
| extTrig | input | 2 | Per-channel asynchronous external trigger |
| dout1 | output | 12 | Channel 1 output register |
| dout2 | output | 12 | Channel 2 output register |

## Verification
The hardest cases are the trigger-gated ones, where the output must stay put while the holding value has already moved. The stimulus therefore first loads each channel through a write that the output must not show. Only then does it fire the wrong-source trigger, the correct software request, or an external edge, checking the output on every cycle of the synchronizer latency. The external input is then held high across a fresh write and later dropped, to show that neither the level nor the falling edge copies data. A second software-trigger copy is ruled out by writing again after the first copy and watching the output stay unchanged.

// File: rtl/dac_regs_pkg.sv
package dac_regs_pkg;
  localparam int NCH    = 2;
  localparam int DATA_W = 12;
  localparam int BUS_W  = 32;
  localparam int ADDR_W = 4;
  localparam int BYTE_W = 8;
  localparam int LANE_W = 16;

  typedef enum logic [1:0] {
    FMT_R12 = 2'd0,
    FMT_L12 = 2'd1,
    FMT_R8  = 2'd2
  } fmt_e;

  // word addresses of the data registers
  localparam logic [ADDR_W-1:0] A_C1_R12 = 4'd0;
  localparam logic [ADDR_W-1:0] A_C1_L12 = 4'd1;
  localparam logic [ADDR_W-1:0] A_C1_R8  = 4'd2;
  localparam logic [ADDR_W-1:0] A_C2_R12 = 4'd3;
  localparam logic [ADDR_W-1:0] A_C2_L12 = 4'd4;
  localparam logic [ADDR_W-1:0] A_C2_R8  = 4'd5;
  localparam logic [ADDR_W-1:0] A_DU_R12 = 4'd6;
  localparam logic [ADDR_W-1:0] A_DU_L12 = 4'd7;
  localparam logic [ADDR_W-1:0] A_DU_R8  = 4'd8;

  typedef struct packed {
    logic [NCH-1:0] holdWr;
    logic [NCH-1:0] outLoad;
    logic           dual;
    fmt_e           fmt;
  } strobe_t;
endpackage

// File: rtl/dacRegCtrl.sv
module dacRegCtrl
  import dac_regs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [NCH-1:0]    trigEn,
  input  logic [NCH-1:0]    trigSrcExt,
  input  logic [NCH-1:0]    swTrig,
  input  logic [NCH-1:0]    extTrig,
  output strobe_t           strb
);
  logic           hit;
  logic [NCH-1:0] chSel;
  logic           isDual;
  fmt_e           fmtDec;

  always_comb begin
    hit    = 1'b1;
    chSel  = '0;
    isDual = 1'b0;
    fmtDec = FMT_R12;
    unique case (wrAddr)
      A_C1_R12: begin chSel = 2'b01; fmtDec = FMT_R12; end
      A_C1_L12: begin chSel = 2'b01; fmtDec = FMT_L12; end
      A_C1_R8:  begin chSel = 2'b01; fmtDec = FMT_R8;  end
      A_C2_R12: begin chSel = 2'b10; fmtDec = FMT_R12; end
      A_C2_L12: begin chSel = 2'b10; fmtDec = FMT_L12; end
      A_C2_R8:  begin chSel = 2'b10; fmtDec = FMT_R8;  end
      A_DU_R12: begin chSel = 2'b11; isDual = 1'b1; fmtDec = FMT_R12; end
      A_DU_L12: begin chSel = 2'b11; isDual = 1'b1; fmtDec = FMT_L12; end
      A_DU_R8:  begin chSel = 2'b11; isDual = 1'b1; fmtDec = FMT_R8;  end
      default:  hit = 1'b0;
    endcase
  end

  logic [NCH-1:0] loadReq;

  for (genvar c = 0; c < NCH; c++) begin : g_trig
    logic [SYNC_STAGES-1:0] syncQ;
    logic                   extPrev;
    logic                   extEdge;
    logic                   swPend;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        syncQ   <= '0;
        extPrev <= 1'b0;
      end else begin
        syncQ   <= {syncQ[SYNC_STAGES-2:0], extTrig[c]};
        extPrev <= syncQ[SYNC_STAGES-1];
      end
    end

    assign extEdge = syncQ[SYNC_STAGES-1] & ~extPrev;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        swPend <= 1'b0;
      end else begin
        swPend <= (swPend & ~loadReq[c])
                | (swTrig[c] & trigEn[c] & ~trigSrcExt[c]);
      end
    end

    always_comb begin
      if (!trigEn[c])         loadReq[c] = 1'b1;
      else if (trigSrcExt[c]) loadReq[c] = extEdge;
      else                    loadReq[c] = swPend;
    end
  end

  always_comb begin
    strb.holdWr  = (wrEn && hit) ? chSel : '0;
    strb.outLoad = loadReq;
    strb.dual    = isDual;
    strb.fmt     = fmtDec;
  end
endmodule

// File: rtl/dacRegPath.sv
module dacRegPath
  import dac_regs_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [BUS_W-1:0]      wrData,
  input  strobe_t               strb,
  output logic [DATA_W-1:0]     dout [NCH]
);
  localparam int PAD_W  = DATA_W - BYTE_W;
  localparam int LEFT_W = LANE_W - DATA_W;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [DATA_W-1:0] hold;
    logic [DATA_W-1:0] fieldVal;
    logic              upper;

    assign upper = strb.dual && (c != 0);

    always_comb begin
      unique case (strb.fmt)
        FMT_L12: fieldVal = upper ? wrData[LANE_W+LEFT_W +: DATA_W]
                                  : wrData[LEFT_W +: DATA_W];
        FMT_R8:  fieldVal = upper ? {wrData[BYTE_W +: BYTE_W], {PAD_W{1'b0}}}
                                  : {wrData[0 +: BYTE_W], {PAD_W{1'b0}}};
        default: fieldVal = upper ? wrData[LANE_W +: DATA_W]
                                  : wrData[0 +: DATA_W];
      endcase
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        hold    <= '0;
        dout[c] <= '0;
      end else begin
        if (strb.holdWr[c])  hold    <= fieldVal;
        if (strb.outLoad[c]) dout[c] <= hold;
      end
    end
  end
endmodule

// File: rtl/dacDataRegs.sv
module dacDataRegs
  import dac_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [BUS_W-1:0]  wrData,
  input  logic [NCH-1:0]    trigEn,
  input  logic [NCH-1:0]    trigSrcExt,
  input  logic [NCH-1:0]    swTrig,
  input  logic [NCH-1:0]    extTrig,
  output logic [DATA_W-1:0] dout1,
  output logic [DATA_W-1:0] dout2
);
  strobe_t           strb;
  logic [DATA_W-1:0] doutArr [NCH];

  dacRegCtrl #(.SYNC_STAGES(2)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .trigEn(trigEn), .trigSrcExt(trigSrcExt), .swTrig(swTrig),
    .extTrig(extTrig), .strb(strb)
  );

  dacRegPath u_path (
    .clk(clk), .rstN(rstN), .wrData(wrData), .strb(strb), .dout(doutArr)
  );

  assign dout1 = doutArr[0];
  assign dout2 = doutArr[1];
endmodule

// File: rtl/dacDataRegsChk.sv
module dacDataRegsChk
  import dac_regs_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [BUS_W-1:0]  wrData,
  input logic [NCH-1:0]    trigEn,
  input logic [DATA_W-1:0] dout1,
  input logic [DATA_W-1:0] dout2,
  input strobe_t           strb
);
  // R2 R8
  c1_r12_auto_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == A_C1_R12 && !trigEn[0]) ##1 !trigEn[0]
      |=> dout1 == $past(wrData[11:0], 2));

  // R5
  dual_r12_auto_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == A_DU_R12 && trigEn == 2'b00) ##1 trigEn == 2'b00
      |=> (dout1 == $past(wrData[11:0], 2)) && (dout2 == $past(wrData[27:16], 2)));

  // R7
  dual_r8_nibble_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == A_DU_R8 && trigEn == 2'b00) ##1 trigEn == 2'b00
      |=> (dout1 == {$past(wrData[7:0], 2), 4'h0}) && (dout2 == {$past(wrData[15:8], 2), 4'h0}));

  // R9
  hold_c1_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.outLoad[0] |=> $stable(dout1));

  // R9
  hold_c2_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.outLoad[1] |=> $stable(dout2));

  // R6
  dual_l12_auto_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == A_DU_L12 && trigEn == 2'b00) ##1 trigEn == 2'b00
      |=> (dout1 == $past(wrData[15:4], 2)) && (dout2 == $past(wrData[31:20], 2)));
endmodule

bind dacDataRegs dacDataRegsChk u_chk (.*);

// File: tb/dacDataRegs_bench.sv
module dacDataRegs_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [1:0]  trigEn = '0;
  logic [1:0]  trigSrcExt = '0;
  logic [1:0]  swTrig = '0;
  logic [1:0]  extTrig = '0;
  logic [11:0] dout1;
  logic [11:0] dout2;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  string       tagQ [$];
  logic [11:0] exp1Q [$];
  logic [11:0] exp2Q [$];

  always #2.5 clk = ~clk;

  dacDataRegs u_dacDataRegs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .trigEn(trigEn), .trigSrcExt(trigSrcExt), .swTrig(swTrig),
    .extTrig(extTrig), .dout1(dout1), .dout2(dout2)
  );

  // monitor: compares queued expectations at the falling edge
  always @(negedge clk) begin
    while (tagQ.size() > 0) begin
      string t;
      logic [11:0] e1, e2;
      t  = tagQ.pop_front();
      e1 = exp1Q.pop_front();
      e2 = exp2Q.pop_front();
      nChecks++;
      if (dout1 !== e1 || dout2 !== e2) begin
        nFails++;
        $display("FAIL %s: dout1=%h dout2=%h expected dout1=%h dout2=%h",
                 t, dout1, dout2, e1, e2);
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  // waits one rising edge, then queues the expected outputs
  task automatic expect2(input string t, input logic [11:0] e1, input logic [11:0] e2);
    @(posedge clk);
    #1;
    tagQ.push_back(t); exp1Q.push_back(e1); exp2Q.push_back(e2);
  endtask

  task automatic swPulse(input logic [1:0] m);
    @(negedge clk);
    swTrig = m;
    @(negedge clk);
    swTrig = '0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    expect2("R1 reset", 12'h000, 12'h000);

    wr(4'd0, 32'hFFFF_FABC);  expect2("R2 R8 ch1 r12", 12'hABC, 12'h000);
    wr(4'd1, 32'hF0F0_9A5F);  expect2("R3 ch1 l12", 12'h9A5, 12'h000);
    wr(4'd2, 32'hFFFF_FF3C);  expect2("R4 ch1 r8", 12'h3C0, 12'h000);
    wr(4'd3, 32'hFFFF_F123);  expect2("R2 ch2 r12", 12'h3C0, 12'h123);
    wr(4'd4, 32'h0000_B7E1);  expect2("R3 ch2 l12", 12'h3C0, 12'hB7E);
    wr(4'd6, 32'hFDEF_F456);  expect2("R5 dual r12", 12'h456, 12'hDEF);
    wr(4'd7, 32'hABC0_1230);  expect2("R6 dual l12", 12'h123, 12'hABC);
    wr(4'd8, 32'hFFFF_5AA5);  expect2("R7 dual r8", 12'hA50, 12'h5A0);
    wr(4'd9, 32'hFFFF_FFFF);  expect2("R13 addr 9", 12'hA50, 12'h5A0);
    wr(4'd15, 32'h1234_5678); expect2("R13 addr 15", 12'hA50, 12'h5A0);
    wr(4'd5, 32'hFFFF_FF77);  expect2("R4 ch2 r8", 12'hA50, 12'h770);

    // ch1 software source, ch2 external source
    @(negedge clk);
    trigEn = 2'b11; trigSrcExt = 2'b10;
    wr(4'd0, 32'h0000_0111);
    expect2("R9 ch1 held", 12'hA50, 12'h770);
    expect2("R9 ch1 held", 12'hA50, 12'h770);
    wr(4'd3, 32'h0000_0222);
    swPulse(2'b10);
    expect2("R12 sw ignored on ext ch2", 12'hA50, 12'h770);
    expect2("R12 sw ignored on ext ch2", 12'hA50, 12'h770);
    swPulse(2'b01);
    expect2("R10 sw copy", 12'h111, 12'h770);
    wr(4'd0, 32'h0000_0333);
    expect2("R10 self clear", 12'h111, 12'h770);
    expect2("R10 self clear", 12'h111, 12'h770);

    @(negedge clk); extTrig = 2'b01;
    expect2("R12 ext ignored on sw ch1", 12'h111, 12'h770);
    expect2("R12 ext ignored on sw ch1", 12'h111, 12'h770);
    expect2("R12 ext ignored on sw ch1", 12'h111, 12'h770);
    expect2("R12 ext ignored on sw ch1", 12'h111, 12'h770);
    @(negedge clk); extTrig = 2'b00;
    repeat (4) @(negedge clk);

    extTrig = 2'b10;
    expect2("R11 sync stage 1", 12'h111, 12'h770);
    expect2("R11 sync stage 2", 12'h111, 12'h770);
    expect2("R11 ext copy", 12'h111, 12'h222);
    wr(4'd3, 32'h0000_0444);
    expect2("R11 level no copy", 12'h111, 12'h222);
    expect2("R11 level no copy", 12'h111, 12'h222);
    @(negedge clk); extTrig = 2'b00;
    expect2("R11 fall no copy", 12'h111, 12'h222);
    expect2("R11 fall no copy", 12'h111, 12'h222);
    expect2("R11 fall no copy", 12'h111, 12'h222);
    expect2("R11 fall no copy", 12'h111, 12'h222);
    @(negedge clk); extTrig = 2'b10;
    expect2("R11 second rise", 12'h111, 12'h222);
    expect2("R11 second rise", 12'h111, 12'h222);
    expect2("R11 second rise", 12'h111, 12'h444);

    @(negedge clk); trigEn = 2'b00; extTrig = 2'b00;
    expect2("R8 trigger off follows", 12'h333, 12'h444);

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule